// File: doc/BRIEF.md
# Host Command Protocol Parser

This block receives a stream of bytes from a host link, one byte per `rx_valid` pulse, and turns them into multi-byte commands. Each protocol step gets a one-byte reply on the response port. The reply is either an acknowledge code or a refusal code. Both codes are parameters, and so is every command byte value.

Three commands exist.

- **Connect.** This is a challenge of three fixed byte pairs. The opening opcode pair counts as the first of the three. Each pair is answered on its own. Once the last pair is answered, a sticky `connected` flag is set.
- **Upload.** The opcode pair is followed by a page count (256-byte pages) and then a bank count (64 KB banks).
- **Download.** It has the same shape as upload.

Upload and download are refused until the connect step has succeeded. When one of them is accepted, the block acknowledges it and then, one cycle later, pulses a start request to a transfer sequencer. The start request carries the direction and both counts.

A timeout guards every wait for the next byte inside a command. If it expires, the block sends a refusal and drops back to idle. While the sequencer reports busy, no new command is taken.

Top module: `host_cmd_parser`

## Requirements
- R1: After reset, `rsp_valid`, `xfer_start` and `connected` are 0.
- R2: If the second opcode byte does not arrive within `TIMEOUT_CYCLES` cycles of the first, the block sends the refusal code and returns to idle.
- R3: For connect, every correct pair is acknowledged in the cycle after its second byte. A wrong byte in any pair is answered with the refusal code, aborts the sequence and leaves `connected` at 0.
- R4: After the third correct connect pair, `connected` goes to 1 and stays at 1 for all later commands.
- R5: An upload or download opcode is followed by a page byte and then a bank byte. No reply is given until the bank byte has arrived.
- R6: An upload or download received while `connected` is 0 is answered with the refusal code, and `xfer_start` does not pulse.
- R7: An accepted upload or download is acknowledged first. `xfer_start` pulses exactly one cycle after the acknowledge. At that point `xfer_dir` is 0 for upload and 1 for download, and `xfer_pages` and `xfer_banks` hold the received counts.
- R8: An opcode pair that matches neither upload nor download in both bytes is answered with the refusal code after its two count bytes, even when connected.
- R9: After any reply or transfer start, the next byte received is treated as the first byte of a new opcode.
- R10: A byte that arrives in idle while `xfer_busy` is 1 is ignored.
- R11: If a connect-pair byte or a count byte does not arrive within `TIMEOUT_CYCLES` cycles, the block sends the refusal code and returns to idle.
- R12: A byte that arrives `TIMEOUT_CYCLES-2` cycles after the previous one is still accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a host byte is on `rx_data` |
| rx_data | input | DW | Host byte |
| xfer_busy | input | 1 | Transfer sequencer is running |
| rsp_valid | output | 1 | One-cycle pulse: reply byte valid |
| rsp_data | output | DW | Reply byte: `ACK_CODE` or `NACK_CODE` |
| xfer_start | output | 1 | One-cycle start request to the sequencer |
| xfer_dir | output | 1 | 0 = upload from host, 1 = download to host |
| xfer_pages | output | DW | Page count of the accepted command |
| xfer_banks | output | DW | Bank count of the accepted command |
| connected | output | 1 | Connect challenge has completed |

## Verification
The bench attacks the byte-timeout boundary from both sides: one byte arrives shortly before expiry, and one wait is left to expire.

- A timer that is off by a few cycles would reply early or never refuse.
- A parser that forgets the connect rule would start a transfer while unconnected.
- A parser that replies to the opcode instead of the bank byte would produce an extra reply.
- A byte sent while the sequencer is busy must not open a command. If it did, the next byte would complete a connect opcode and draw an acknowledge instead of a timeout refusal.
- The start pulse is timed against the acknowledge. This catches a start that comes too early or carries stale counts or the wrong direction.

// File: rtl/hcp_pkg.sv
// Shared types of the host command parser.
// Assumes nothing beyond a single clock domain.
package hcp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP2,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_PAGE,
        ST_BANK,
        ST_START
    } hcp_state_t;

    typedef enum logic [1:0] {
        OPK_UPLOAD,
        OPK_DOWNLOAD,
        OPK_OTHER
    } hcp_kind_t;
endpackage

// File: rtl/hcp_timer.sv
// Inter-byte timeout counter.
// Counts cycles while `run` is high and no byte arrives.
// `expired` is raised in the cycle that completes LIMIT waiting cycles.
// Assumes `restart` pulses on every accepted byte.
module hcp_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // count waiting cycles, saturating at LAST
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // expiry when the window is used up and no byte is present
    always_comb begin
        expired = run && !restart && (cnt == LAST);
    end

    // R2
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R11
    tmr_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/hcp_op_decode.sv
// Classifies an opcode byte pair as upload, download or other.
// Both bytes must match for a known kind.
module hcp_op_decode #(
    parameter int          DW    = 8,
    parameter logic [DW-1:0] UP_B0 = 8'h55,
    parameter logic [DW-1:0] UP_B1 = 8'h50,
    parameter logic [DW-1:0] DN_B0 = 8'h44,
    parameter logic [DW-1:0] DN_B1 = 8'h4C
) (
    input  logic [DW-1:0]      op_hi,
    input  logic [DW-1:0]      op_lo,
    output hcp_pkg::hcp_kind_t kind
);
    // pairwise compare against both known opcodes
    always_comb begin
        if (op_hi == UP_B0 && op_lo == UP_B1) begin
            kind = hcp_pkg::OPK_UPLOAD;
        end else if (op_hi == DN_B0 && op_lo == DN_B1) begin
            kind = hcp_pkg::OPK_DOWNLOAD;
        end else begin
            kind = hcp_pkg::OPK_OTHER;
        end
    end
endmodule

// File: rtl/host_cmd_parser.sv
// Host command protocol parser.
// Decodes connect, upload and download commands from a byte stream.
// Every step is answered with a one-byte reply.
// An accepted transfer is handed to the sequencer one cycle after its acknowledge.
// Assumes the sequencer raises xfer_busy in the cycle after xfer_start.
module host_cmd_parser #(
    parameter int            DW             = 8,
    parameter int            TIMEOUT_CYCLES = 64,
    parameter logic [DW-1:0] ACK_CODE       = 8'h06,
    parameter logic [DW-1:0] NACK_CODE      = 8'h15,
    parameter logic [DW-1:0] CON_B0         = 8'h43,
    parameter logic [DW-1:0] CON_B1         = 8'h4E,
    parameter logic [DW-1:0] CON_B2         = 8'h31,
    parameter logic [DW-1:0] CON_B3         = 8'h32,
    parameter logic [DW-1:0] CON_B4         = 8'h33,
    parameter logic [DW-1:0] CON_B5         = 8'h34,
    parameter logic [DW-1:0] UP_B0          = 8'h55,
    parameter logic [DW-1:0] UP_B1          = 8'h50,
    parameter logic [DW-1:0] DN_B0          = 8'h44,
    parameter logic [DW-1:0] DN_B1          = 8'h4C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          xfer_busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          xfer_start,
    output logic          xfer_dir,
    output logic [DW-1:0] xfer_pages,
    output logic [DW-1:0] xfer_banks,
    output logic          connected
);
    import hcp_pkg::*;

    localparam int PAIRS = 2;  // challenge pairs after the opcode pair

    hcp_state_t     state;
    hcp_kind_t      kind;
    logic [DW-1:0]  op_hi, op_lo, pair_hi;
    logic           pair_idx;
    logic           waiting, tmo;
    logic [2*DW-1:0] pair_exp [PAIRS];

    assign pair_exp[0] = {CON_B2, CON_B3};
    assign pair_exp[1] = {CON_B4, CON_B5};

    // states in which a further byte is awaited under timeout
    always_comb begin
        waiting = (state == ST_OP2) || (state == ST_PAIR_A) || (state == ST_PAIR_B)
               || (state == ST_PAGE) || (state == ST_BANK);
    end

    hcp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .restart (rx_valid),
        .expired (tmo)
    );

    hcp_op_decode #(.DW(DW), .UP_B0(UP_B0), .UP_B1(UP_B1),
                    .DN_B0(DN_B0), .DN_B1(DN_B1)) u_dec (
        .op_hi (op_hi),
        .op_lo (op_lo),
        .kind  (kind)
    );

    // command sequencing, replies and start request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_hi      <= '0;
            op_lo      <= '0;
            pair_hi    <= '0;
            pair_idx   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            xfer_start <= 1'b0;
            xfer_dir   <= 1'b0;
            xfer_pages <= '0;
            xfer_banks <= '0;
            connected  <= 1'b0;
        end else begin
            rsp_valid  <= 1'b0;
            xfer_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (rx_valid && !xfer_busy) begin
                        op_hi <= rx_data;
                        state <= ST_OP2;
                    end
                end
                ST_OP2: begin
                    if (rx_valid) begin
                        if (op_hi == CON_B0) begin
                            rsp_valid <= 1'b1;
                            if (rx_data == CON_B1) begin
                                rsp_data <= ACK_CODE;
                                pair_idx <= 1'b0;
                                state    <= ST_PAIR_A;
                            end else begin
                                rsp_data <= NACK_CODE;
                                state    <= ST_IDLE;
                            end
                        end else begin
                            op_lo <= rx_data;
                            state <= ST_PAGE;
                        end
                    end else if (tmo) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= NACK_CODE;
                        state     <= ST_IDLE;
                    end
                end
                ST_PAIR_A: begin
                    if (rx_valid) begin
                        pair_hi <= rx_data;
                        state   <= ST_PAIR_B;
                    end else if (tmo) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= NACK_CODE;
                        state     <= ST_IDLE;
                    end
                end
                ST_PAIR_B: begin
                    if (rx_valid) begin
                        rsp_valid <= 1'b1;
                        if ({pair_hi, rx_data} == pair_exp[pair_idx]) begin
                            rsp_data <= ACK_CODE;
                            if (pair_idx) begin
                                connected <= 1'b1;
                                state     <= ST_IDLE;
                            end else begin
                                pair_idx <= 1'b1;
                                state    <= ST_PAIR_A;
                            end
                        end else begin
                            rsp_data <= NACK_CODE;
                            state    <= ST_IDLE;
                        end
                    end else if (tmo) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= NACK_CODE;
                        state     <= ST_IDLE;
                    end
                end
                ST_PAGE: begin
                    if (rx_valid) begin
                        xfer_pages <= rx_data;
                        state      <= ST_BANK;
                    end else if (tmo) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= NACK_CODE;
                        state     <= ST_IDLE;
                    end
                end
                ST_BANK: begin
                    if (rx_valid) begin
                        xfer_banks <= rx_data;
                        rsp_valid  <= 1'b1;
                        if (connected && kind != OPK_OTHER) begin
                            rsp_data <= ACK_CODE;
                            xfer_dir <= (kind == OPK_DOWNLOAD);
                            state    <= ST_START;
                        end else begin
                            rsp_data <= NACK_CODE;
                            state    <= ST_IDLE;
                        end
                    end else if (tmo) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= NACK_CODE;
                        state     <= ST_IDLE;
                    end
                end
                ST_START: begin
                    xfer_start <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    start_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> ($past(rsp_valid) && $past(rsp_data) == ACK_CODE));
    // R6
    start_needs_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> connected);
    // R4
    conn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        connected |=> connected);
    // R3
    rsp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data == ACK_CODE || rsp_data == NACK_CODE));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && xfer_busy) |=> state == ST_IDLE);
    // R9
    one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && xfer_start));
endmodule

// File: tb/host_cmd_parser_tb.sv
module host_cmd_parser_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 20;
    localparam logic [7:0] ACK = 8'h06, NACK = 8'h15;

    logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0, xfer_busy = 1'b0;
    logic [7:0] rx_data = '0;
    logic rsp_valid, xfer_start, xfer_dir, connected;
    logic [7:0] rsp_data, xfer_pages, xfer_banks;

    int checks = 0, errors = 0, cyc = 0;
    int rsp_cnt = 0, start_cnt = 0, rsp_cyc = 0, start_cyc = 0;
    logic [7:0] last_rsp = '0, st_pages = '0, st_banks = '0;
    logic st_dir = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_cmd_parser #(.TIMEOUT_CYCLES(TMO), .ACK_CODE(ACK), .NACK_CODE(NACK)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .xfer_busy(xfer_busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .xfer_start(xfer_start), .xfer_dir(xfer_dir), .xfer_pages(xfer_pages),
        .xfer_banks(xfer_banks), .connected(connected)
    );

    // record registered outputs once per cycle
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && rsp_valid) begin
            rsp_cnt <= rsp_cnt + 1; last_rsp <= rsp_data; rsp_cyc <= cyc;
        end
        if (rst_n && xfer_start) begin
            start_cnt <= start_cnt + 1; start_cyc <= cyc;
            st_dir <= xfer_dir; st_pages <= xfer_pages; st_banks <= xfer_banks;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!rsp_valid && !xfer_start && !connected, "R1", {rsp_valid, xfer_start, connected}, 0);
    endtask

    task automatic t_op_timeout;
        int c0 = rsp_cnt;
        send(8'h43);
        settle(TMO + 4);
        chk(rsp_cnt == c0 + 1 && last_rsp == NACK, "R2", last_rsp, NACK);
    endtask

    task automatic t_unconnected;
        int c0 = rsp_cnt;
        send(8'h55); send(8'h50); send(8'h03); settle(2);
        chk(rsp_cnt == c0, "R5", rsp_cnt - c0, 0);
        send(8'h01); settle(3);
        chk(rsp_cnt == c0 + 1 && last_rsp == NACK, "R6", last_rsp, NACK);
        chk(start_cnt == 0, "R6", start_cnt, 0);
    endtask

    task automatic t_bad_connect;
        int c0 = rsp_cnt;
        send(8'h43); send(8'h4E); settle(2);
        chk(rsp_cnt == c0 + 1 && last_rsp == ACK, "R3", last_rsp, ACK);
        send(8'h31); send(8'h99); settle(2);
        chk(rsp_cnt == c0 + 2 && last_rsp == NACK, "R3", last_rsp, NACK);
        chk(!connected, "R3", connected, 0);
        // R9: next byte starts a new opcode, so a wrong second byte of connect refuses at once
        send(8'h43); send(8'h00); settle(2);
        chk(rsp_cnt == c0 + 3 && last_rsp == NACK, "R9", last_rsp, NACK);
    endtask

    task automatic t_pair_timeout;
        int c0 = rsp_cnt;
        send(8'h43); send(8'h4E); send(8'h31);
        settle(TMO + 4);
        chk(rsp_cnt == c0 + 2 && last_rsp == NACK, "R11", last_rsp, NACK);
    endtask

    task automatic t_connect;
        int c0 = rsp_cnt;
        send(8'h43); send(8'h4E);
        send(8'h31); settle(TMO - 3); send(8'h32); settle(2);
        chk(rsp_cnt == c0 + 2 && last_rsp == ACK, "R12", last_rsp, ACK);
        chk(!connected, "R4", connected, 0);
        send(8'h33); send(8'h34); settle(1);
        chk(connected == 1'b1, "R4", connected, 1);
        settle(1);
        chk(rsp_cnt == c0 + 3 && last_rsp == ACK, "R3", last_rsp, ACK);
    endtask

    task automatic t_count_timeout;
        int c0 = rsp_cnt;
        send(8'h44); send(8'h4C); send(8'h05);
        settle(TMO + 4);
        chk(rsp_cnt == c0 + 1 && last_rsp == NACK && start_cnt == 0, "R11", last_rsp, NACK);
    endtask

    task automatic t_xfer(input logic [7:0] o0, o1, pg, bk, input logic dir);
        int c0 = rsp_cnt, s0 = start_cnt;
        send(o0); send(o1); send(pg); send(bk); settle(3);
        chk(rsp_cnt == c0 + 1 && last_rsp == ACK, "R7", last_rsp, ACK);
        chk(start_cnt == s0 + 1 && start_cyc == rsp_cyc + 1, "R7", start_cyc - rsp_cyc, 1);
        chk(st_dir == dir && st_pages == pg && st_banks == bk, "R7",
            {st_dir, st_pages, st_banks}, {dir, pg, bk});
    endtask

    task automatic t_unknown;
        int c0 = rsp_cnt, s0 = start_cnt;
        send(8'h55); send(8'h4C); send(8'h01); send(8'h01); settle(3);
        chk(rsp_cnt == c0 + 1 && last_rsp == NACK && start_cnt == s0, "R8", last_rsp, NACK);
        chk(connected == 1'b1, "R4", connected, 1);
    endtask

    task automatic t_busy;
        int c0 = rsp_cnt;
        @(negedge clk); xfer_busy = 1'b1;
        send(8'h43);
        @(negedge clk); xfer_busy = 1'b0;
        send(8'h4E);
        settle(TMO + 4);
        chk(rsp_cnt == c0 + 1 && last_rsp == NACK, "R10", last_rsp, NACK);
    endtask

    initial begin
        settle(3);
        @(negedge clk); rst_n = 1'b1;
        settle(1);
        t_reset();
        t_op_timeout();
        t_unconnected();
        t_bad_connect();
        t_pair_timeout();
        t_connect();
        t_count_timeout();
        t_xfer(8'h55, 8'h50, 8'h10, 8'h02, 1'b0);
        t_xfer(8'h44, 8'h4C, 8'hFF, 8'h00, 1'b1);
        t_unknown();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule